// File: doc/BRIEF.md
# Boot Page Address Translator

This block sits between a processor core's instruction fetch path and the memory routing logic. After reset, the core can only reach a single 4-Kbyte page, from 0x0_FFFF_F000 to 0x0_FFFF_FFFF. Its first fetch is a burst read at 0x0_FFFF_FFE0, and its first instruction sits at 0x0_FFFF_FFFC. When the boot code lives somewhere else, software or a host enables the translator and programs a boot page number. Every request that lands in the reset page then has its page number replaced and its 12-bit page offset kept.

Translation only moves the address. It never picks the interface that serves the request. Routing comes from a separate 1-Mbyte routing window, which has its own enable, a base held as address bits [35:20], and a 4-bit target code. A translated address that falls in this window reports the programmed target. An address that misses the window but lies in the default 8-Mbyte boot ROM range (0x0_FF80_0000 to 0x0_FFFF_FFFF) goes to the local bus. Any other address also goes to the local bus, but with a miss flag raised.

Both settings are held in 32-bit registers on a simple register bus. The bus has an offset, a write strobe and write data, and a read port that answers at once. Each result is registered one cycle after the request strobe.

Top module: `boot_page_remap`

## Requirements
- R1: After reset, both registers read 0, translation and the window are disabled, and validOut is 0.
- R2: While translation is disabled, addrOut equals the request address, even if a boot page number is programmed.
- R3: While translation is enabled and request bits [35:12] equal 0x0FFFFF, addrOut is the programmed 24-bit boot page number followed by request bits [11:0].
- R4: A request whose bits [35:12] differ from 0x0FFFFF is passed through unchanged, even while translation is enabled.
- R5: The translation register sits at offset 0x20. Bit 31 is the enable and bits [23:0] hold the boot page number. Bits [30:24] ignore writes and read 0.
- R6: The window register sits at offset 0x24. Bit 31 is the enable, bits [19:16] hold the target code and bits [15:0] hold the window base (address bits [35:20]). Bits [30:20] ignore writes and read 0.
- R7: When the window is enabled and bits [35:20] of the (possibly translated) address equal the base, tgtOut is the programmed target code and missOut is 0. The window wins over the default boot range. A disabled window never hits.
- R8: On a window miss, an address in 0x0_FF80_0000 to 0x0_FFFF_FFFF gives tgtOut 4'b0100 (local bus) and missOut 0.
- R9: On a window miss, an address outside that range gives tgtOut 4'b0100 and missOut 1.
- R10: The outputs update on the clock edge that samples reqValid high. validOut is high for exactly the cycles that follow a sampled request. With no request, addrOut, tgtOut and missOut hold their values.
- R11: A write to any other offset changes no register, and a read of any other offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 8 | Register byte offset |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr |
| reqValid | input | 1 | Fetch request strobe |
| reqAddr | input | 36 | Fetch request address |
| validOut | output | 1 | Result valid, one cycle after reqValid |
| addrOut | output | 36 | Translated address |
| tgtOut | output | 4 | Target interface code |
| missOut | output | 1 | No window and not in default boot range |

## Verification
Assertions check the following on every cycle:
- the one-cycle relation between reqValid and validOut;
- that outputs hold while idle;
- pass-through of addresses when translation is off or the address lies outside the reset page;
- the local-bus code that must accompany a miss;
- zero readback of reserved register bits.

The bench's scenarios cover behaviour that needs chosen register contents:
- the exact translated page;
- window priority over the boot range;
- that a disabled window with a matching base still misses;
- the range edges and high address bits that must defeat page matching;
- behaviour right after reset.

// File: rtl/boot_remap_pkg.sv
package boot_remap_pkg;
  localparam int ADDR_W     = 36;
  localparam int PAGE_OFF_W = 12;
  localparam int WIN_OFF_W  = 20;
  localparam int ROM_OFF_W  = 23;
  localparam int TGT_W      = 4;
  localparam int DATA_W     = 32;
  localparam int REG_AW     = 8;

  localparam int PN_W   = ADDR_W - PAGE_OFF_W;
  localparam int WB_W   = ADDR_W - WIN_OFF_W;
  localparam int ROM_PW = ADDR_W - ROM_OFF_W;

  localparam logic [REG_AW-1:0] XLATE_OFS = REG_AW'(8'h20);
  localparam logic [REG_AW-1:0] WIN_OFS   = REG_AW'(8'h24);

  localparam logic [PN_W-1:0]   RST_PN   = PN_W'(32'h000F_FFFF);
  localparam logic [ROM_PW-1:0] ROM_PFX  = ROM_PW'(32'h0000_01FF);
  localparam logic [TGT_W-1:0]  TGT_LBUS = TGT_W'(4'b0100);

  localparam int EN_BIT = DATA_W - 1;
  localparam logic [DATA_W-1:0] XLATE_MASK =
    (DATA_W'(1) << EN_BIT) | ((DATA_W'(1) << PN_W) - DATA_W'(1));
  localparam logic [DATA_W-1:0] WIN_MASK =
    (DATA_W'(1) << EN_BIT) | ((DATA_W'(1) << (WB_W + TGT_W)) - DATA_W'(1));

  typedef struct packed {
    logic              xlateEn;
    logic [PN_W-1:0]   bootPage;
    logic              winEn;
    logic [WB_W-1:0]   winBase;
    logic [TGT_W-1:0]  winTgt;
  } remapCfg_t;
endpackage

// File: rtl/remap_regs.sv
module remap_regs
  import boot_remap_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output remapCfg_t         cfg
);
  logic [DATA_W-1:0] xlateImg;
  logic [DATA_W-1:0] winImg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xlateImg <= '0;
      winImg   <= '0;
    end else if (regWrEn) begin
      if (regAddr == XLATE_OFS) xlateImg <= regWrData & XLATE_MASK;
      if (regAddr == WIN_OFS)   winImg   <= regWrData & WIN_MASK;
    end
  end

  always_comb begin
    regRdData = '0;
    if (regAddr == XLATE_OFS) regRdData = xlateImg;
    else if (regAddr == WIN_OFS) regRdData = winImg;
  end

  always_comb begin
    cfg.xlateEn  = xlateImg[EN_BIT];
    cfg.bootPage = xlateImg[PN_W-1:0];
    cfg.winEn    = winImg[EN_BIT];
    cfg.winTgt   = winImg[WB_W+TGT_W-1:WB_W];
    cfg.winBase  = winImg[WB_W-1:0];
  end

  // R5
  xlate_rsvd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == XLATE_OFS) |-> ((regRdData & ~XLATE_MASK) == '0));

  // R6
  win_rsvd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == WIN_OFS) |-> ((regRdData & ~WIN_MASK) == '0));

  // R11
  other_ofs_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr != XLATE_OFS && regAddr != WIN_OFS) |-> (regRdData == '0));
endmodule

// File: rtl/remap_path.sv
module remap_path
  import boot_remap_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  remapCfg_t         cfg,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              validOut,
  output logic [ADDR_W-1:0] addrOut,
  output logic [TGT_W-1:0]  tgtOut,
  output logic              missOut
);
  logic              inPage;
  logic [ADDR_W-1:0] xAddr;
  logic              winHit;
  logic              inRom;
  logic [TGT_W-1:0]  tgtNext;
  logic              missNext;

  always_comb begin
    inPage = (reqAddr[ADDR_W-1:PAGE_OFF_W] == RST_PN);
    xAddr  = (cfg.xlateEn && inPage) ?
             {cfg.bootPage, reqAddr[PAGE_OFF_W-1:0]} : reqAddr;
    winHit = cfg.winEn && (xAddr[ADDR_W-1:WIN_OFF_W] == cfg.winBase);
    inRom  = (xAddr[ADDR_W-1:ROM_OFF_W] == ROM_PFX);
    if (winHit) begin
      tgtNext  = cfg.winTgt;
      missNext = 1'b0;
    end else begin
      tgtNext  = TGT_LBUS;
      missNext = !inRom;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validOut <= 1'b0;
      addrOut  <= '0;
      tgtOut   <= TGT_LBUS;
      missOut  <= 1'b0;
    end else begin
      validOut <= reqValid;
      if (reqValid) begin
        addrOut <= xAddr;
        tgtOut  <= tgtNext;
        missOut <= missNext;
      end
    end
  end

  // R10
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> validOut);

  // R10
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !validOut);

  // R10
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> ($stable(addrOut) && $stable(tgtOut) && $stable(missOut)));

  // R2
  pass_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !cfg.xlateEn) |=> (addrOut == $past(reqAddr)));

  // R4
  pass_outside_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqAddr[ADDR_W-1:PAGE_OFF_W] != RST_PN) |=>
    (addrOut == $past(reqAddr)));

  // R9
  miss_lbus_chk: assert property (@(posedge clk) disable iff (!rstN)
    missOut |-> (tgtOut == TGT_LBUS));
endmodule

// File: rtl/boot_page_remap.sv
module boot_page_remap
  import boot_remap_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              validOut,
  output logic [ADDR_W-1:0] addrOut,
  output logic [TGT_W-1:0]  tgtOut,
  output logic              missOut
);
  remapCfg_t cfg;

  remap_regs u_regs (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .cfg(cfg)
  );

  remap_path u_path (
    .clk(clk), .rstN(rstN), .cfg(cfg), .reqValid(reqValid),
    .reqAddr(reqAddr), .validOut(validOut), .addrOut(addrOut),
    .tgtOut(tgtOut), .missOut(missOut)
  );
endmodule

// File: tb/boot_page_remap_tb.sv
module boot_page_remap_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  regAddr = 8'h00;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        reqValid = 1'b0;
  logic [35:0] reqAddr = '0;
  logic        validOut;
  logic [35:0] addrOut;
  logic [3:0]  tgtOut;
  logic        missOut;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  boot_page_remap u_dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .reqValid(reqValid),
    .reqAddr(reqAddr), .validOut(validOut), .addrOut(addrOut),
    .tgtOut(tgtOut), .missOut(missOut)
  );

  // vector: xlate reg, window reg, request, expected addr, target, miss
  localparam int NV = 10;
  localparam logic [140:0] VEC [NV] = '{
    {32'h0000_0000, 32'h0000_0000, 36'h0_FFFF_FFE0, 36'h0_FFFF_FFE0, 4'h4, 1'b0}, // R2 R8
    {32'h8000_1234, 32'h0000_0000, 36'h0_FFFF_FFFC, 36'h0_0123_4FFC, 4'h4, 1'b1}, // R3 R9
    {32'h8000_1234, 32'h800F_0012, 36'h0_FFFF_FFFC, 36'h0_0123_4FFC, 4'hF, 1'b0}, // R3 R7
    {32'h8000_1234, 32'h800F_0012, 36'h0_FFFF_EFFC, 36'h0_FFFF_EFFC, 4'h4, 1'b0}, // R4 R8
    {32'h8000_1234, 32'h800F_0013, 36'h0_FFFF_F000, 36'h0_0123_4000, 4'h4, 1'b1}, // R7 miss
    {32'h0000_0000, 32'h8008_0FFF, 36'h0_FFF0_0010, 36'h0_FFF0_0010, 4'h8, 1'b0}, // R7 priority
    {32'h0000_0000, 32'h0008_0FFF, 36'h0_FFF0_0010, 36'h0_FFF0_0010, 4'h4, 1'b0}, // R7 disabled
    {32'h0000_1234, 32'h0000_0000, 36'h0_FFFF_FFE0, 36'h0_FFFF_FFE0, 4'h4, 1'b0}, // R2
    {32'h80AB_CDEF, 32'h0000_0000, 36'hF_FFFF_F000, 36'hF_FFFF_F000, 4'h4, 1'b1}, // R4 R9
    {32'h80AB_CDEF, 32'h0000_0000, 36'h0_FFFF_F008, 36'hA_BCDE_F008, 4'h4, 1'b1}  // R3
  };

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic sendReq(input logic [35:0] a);
    @(negedge clk);
    reqAddr = a; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nFails++; nChecks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin : main
    logic [31:0] rd;
    logic [35:0] held;
    repeat (3) @(negedge clk);
    // R1 reset state while held in reset
    chk(validOut == 1'b0, "R1 validOut in reset", validOut, 0);
    rstN = 1'b1;
    rdReg(8'h20, rd); chk(rd == 0, "R1 xlate reg reset", rd, 0);
    rdReg(8'h24, rd); chk(rd == 0, "R1 window reg reset", rd, 0);
    // R1 first fetch passes through after reset
    sendReq(36'h0_FFFF_FFE0);
    chk(validOut == 1'b1, "R10 validOut after request", validOut, 1);
    chk(addrOut == 36'h0_FFFF_FFE0, "R1 first fetch untranslated", addrOut, 36'h0_FFFF_FFE0);
    chk(tgtOut == 4'h4 && !missOut, "R8 first fetch in boot range", {tgtOut, missOut}, 5'h08);

    // vector table
    for (int i = 0; i < NV; i++) begin
      logic [140:0] v;
      v = VEC[i];
      wrReg(8'h20, v[140:109]);
      wrReg(8'h24, v[108:77]);
      sendReq(v[76:41]);
      chk(validOut == 1'b1, $sformatf("R10 vec%0d valid", i), validOut, 1);
      chk(addrOut == v[40:5], $sformatf("R3 vec%0d addr", i), addrOut, v[40:5]);
      chk(tgtOut == v[4:1], $sformatf("R7 vec%0d target", i), tgtOut, v[4:1]);
      chk(missOut == v[0], $sformatf("R9 vec%0d miss", i), missOut, v[0]);
    end

    // R10 hold and drop of validOut
    held = addrOut;
    @(negedge clk); reqAddr = 36'h0_0000_0000;
    @(negedge clk);
    chk(validOut == 1'b0, "R10 validOut drops", validOut, 0);
    chk(addrOut == held, "R10 addrOut holds while idle", addrOut, held);

    // R10 back-to-back requests
    wrReg(8'h20, 32'h0000_0000);
    wrReg(8'h24, 32'h0000_0000);
    @(negedge clk); reqValid = 1'b1; reqAddr = 36'h0_FF80_0000;
    @(negedge clk); reqAddr = 36'h0_FF7F_FFFF;
    chk(validOut && addrOut == 36'h0_FF80_0000 && !missOut,
        "R8 range low edge", {validOut, missOut}, 2'b10);
    @(negedge clk); reqValid = 1'b0;
    chk(validOut && addrOut == 36'h0_FF7F_FFFF && missOut && tgtOut == 4'h4,
        "R9 just below range", {validOut, missOut}, 2'b11);

    // R5 reserved bits of translation register
    wrReg(8'h20, 32'hFFFF_FFFF);
    rdReg(8'h20, rd); chk(rd == 32'h80FF_FFFF, "R5 xlate reserved readback", rd, 32'h80FF_FFFF);
    // R6 reserved bits of window register
    wrReg(8'h24, 32'hFFFF_FFFF);
    rdReg(8'h24, rd); chk(rd == 32'h800F_FFFF, "R6 window reserved readback", rd, 32'h800F_FFFF);

    // R11 unmapped offset
    wrReg(8'h00, 32'h0000_0000);
    wrReg(8'h28, 32'h0000_0000);
    rdReg(8'h00, rd); chk(rd == 0, "R11 unmapped read", rd, 0);
    rdReg(8'h20, rd); chk(rd == 32'h80FF_FFFF, "R11 xlate unchanged", rd, 32'h80FF_FFFF);
    rdReg(8'h24, rd); chk(rd == 32'h800F_FFFF, "R11 window unchanged", rd, 32'h800F_FFFF);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule